// File: doc/BRIEF.md
# Auto-Increment Bank-Switching Address Sequencer

This block produces the bank, row and column address stream for a four-bank synchronous DRAM of 1,536 rows by 256 columns per bank. Each location holds 32 bits. A start position is loaded first, and a run strobe then starts the stream. From then on the column advances by one on every enabled clock. At the end of a page the stream moves to the next bank on its own. Once the last bank has been passed, the row moves up by one. The stream does not stop at a page or bank edge. It keeps going until a stop (precharge) request arrives.

The clock enable masks whole clocks. On a masked clock, nothing changes. Two single-cycle indicators help the memory controller track the stream. The first marks an automatic bank change. The second marks the row counter rolling over from its last row back to row 0.

Top module: `bank_seq_addr_gen`

## Requirements
- R1: After reset: bank_o = 0, row_o = 0, col_o = 0, running_o = 0, bank_sw_o = 0 and row_wrap_o = 0.
- R2: On an enabled clock with load_i high and stop_i low, the outputs take bank_i, row_i and col_i, and running_o clears. A row_i value of NUM_ROWS or more loads row 0.
- R3: On an enabled clock with run_i high and no stop or load, running_o sets. On each enabled clock where running_o was already 1 and there is no stop or load, col_o goes up by 1. The first advance therefore comes on the clock after the run strobe.
- R4: When an advance takes col_o from NUM_COLS-1 to 0, the bank moves to the next one. Bank codes are bank_o = {BA1,BA0}: 0 (A), then 1 (B), then 2 (C), then 3 (D), then back to 0.
- R5: When an advance takes the bank from D (3) back to A (0), row_o goes up by 1. Column, bank and row all change on the same clock.
- R6: When that row step starts from row NUM_ROWS-1, row_o becomes 0. row_wrap_o is then high for exactly the one cycle that follows this edge.
- R7: bank_sw_o is high for exactly the one cycle after each automatic bank change. A load that changes the bank does not raise it.
- R8: On a clock where cke_i is low, bank_o, row_o, col_o and running_o keep their values. bank_sw_o and row_wrap_o are low after that clock.
- R9: On an enabled clock, stop_i clears running_o and keeps the address unchanged. It wins over load_i and run_i on the same clock.
- R10: stop_i, load_i and run_i have no effect on a clock where cke_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock enable; low masks the clock |
| load_i | input | 1 | Load the start address |
| bank_i | input | BANK_W | Start bank |
| row_i | input | ROW_W | Start row |
| col_i | input | COL_W | Start column |
| run_i | input | 1 | Start the serial stream |
| stop_i | input | 1 | Stop/precharge request |
| bank_o | output | BANK_W | Current bank |
| row_o | output | ROW_W | Current row |
| col_o | output | COL_W | Current column |
| running_o | output | 1 | Stream is active |
| bank_sw_o | output | 1 | One-cycle pulse after an automatic bank change |
| row_wrap_o | output | 1 | One-cycle pulse after the row rolls over to 0 |

## Verification
The bench builds the block with its default values: 4 banks, 1,536 rows and 256 columns. With these values the widths are 2, 11 and 8 bits. Loading a start address close to the end of a page, the last bank or the last row brings every carry within a few cycles of the load. Among these are the roll from row 1,535 to 0 and an out-of-range row load. One run also covers a full pass over all four banks, so the A, B, C, D order and the row step are seen in a single continuous stream.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;
  typedef enum logic [2:0] {
    CMD_MASK,
    CMD_STOP,
    CMD_LOAD,
    CMD_STEP,
    CMD_IDLE
  } seq_cmd_e;
endpackage

// File: rtl/asq_ctrl.sv
module asq_ctrl
  import addr_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic load_i,
  input  logic run_i,
  input  logic stop_i,
  output logic load_en_o,
  output logic step_o,
  output logic running_o
);
  seq_cmd_e cmd;
  logic     running_q;

  // priority: mask > stop > load > step
  always_comb begin
    if (!cke_i)         cmd = CMD_MASK;
    else if (stop_i)    cmd = CMD_STOP;
    else if (load_i)    cmd = CMD_LOAD;
    else if (running_q) cmd = CMD_STEP;
    else                cmd = CMD_IDLE;
  end

  assign load_en_o = (cmd == CMD_LOAD);
  assign step_o    = (cmd == CMD_STEP);
  assign running_o = running_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_STOP, CMD_LOAD: running_q <= 1'b0;
        CMD_STEP, CMD_IDLE: if (run_i) running_q <= 1'b1;
        default:            running_q <= running_q;
      endcase
    end
  end

  assert_stop_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && stop_i |=> !running_o);
  assert_mask_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(running_o));
  assert_run_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && run_i && !stop_i && !load_i |=> running_o);
endmodule

// File: rtl/asq_wrap_ctr.sv
module asq_wrap_ctr #(
  parameter int unsigned LIMIT = 256,
  parameter int unsigned W     = $clog2(LIMIT)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  localparam logic [W-1:0] MAX_V = W'(LIMIT - 1);

  logic [W-1:0] val_q;
  logic         at_max;

  assign at_max  = (val_q == MAX_V);
  assign carry_o = inc_i & at_max;
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= (load_val_i > MAX_V) ? '0 : load_val_i;
    else if (inc_i)  val_q <= at_max ? '0 : val_q + 1'b1;
  end

  // also covers the bank (R4) and row (R5) steps
  assert_ctr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i |=> (val_q == W'($past(val_q) + 1'b1)) || ($past(at_max) && val_q == '0));
  assert_load_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> val_q <= MAX_V);
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !load_i |=> $stable(val_q));
endmodule

// File: rtl/bank_seq_addr_gen.sv
module bank_seq_addr_gen #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned NUM_ROWS  = 1536,
  parameter int unsigned NUM_COLS  = 256,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned ROW_W    = $clog2(NUM_ROWS),
  localparam int unsigned COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              load_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              run_i,
  input  logic              stop_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              running_o,
  output logic              bank_sw_o,
  output logic              row_wrap_o
);
  logic load_en, step;
  logic col_carry, bank_carry, row_carry;
  logic bank_sw_q, row_wrap_q;

  asq_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cke_i     (cke_i),
    .load_i    (load_i),
    .run_i     (run_i),
    .stop_i    (stop_i),
    .load_en_o (load_en),
    .step_o    (step),
    .running_o (running_o)
  );

  asq_wrap_ctr #(.LIMIT(NUM_COLS)) u_col (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_en),
    .load_val_i (col_i),
    .inc_i      (step),
    .val_o      (col_o),
    .carry_o    (col_carry)
  );

  asq_wrap_ctr #(.LIMIT(NUM_BANKS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_en),
    .load_val_i (bank_i),
    .inc_i      (col_carry),
    .val_o      (bank_o),
    .carry_o    (bank_carry)
  );

  asq_wrap_ctr #(.LIMIT(NUM_ROWS)) u_row (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_en),
    .load_val_i (row_i),
    .inc_i      (bank_carry),
    .val_o      (row_o),
    .carry_o    (row_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_sw_q  <= 1'b0;
      row_wrap_q <= 1'b0;
    end else begin
      bank_sw_q  <= col_carry;
      row_wrap_q <= row_carry;
    end
  end

  assign bank_sw_o  = bank_sw_q;
  assign row_wrap_o = row_wrap_q;

  assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(bank_o) && $stable(row_o) && $stable(col_o) && !bank_sw_o && !row_wrap_o);
  assert_bank_sw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_sw_o |-> col_o == '0 && bank_o != $past(bank_o));
  assert_row_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_wrap_o |-> row_o == '0 && bank_o == '0 && col_o == '0 && bank_sw_o);
  assert_stop_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && stop_i |=> $stable(bank_o) && $stable(row_o) && $stable(col_o));
  assert_pulse_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_sw_o |=> !bank_sw_o);
endmodule

// File: tb/tb_bank_seq_addr_gen.sv
module tb_bank_seq_addr_gen;
  localparam int NB = 4, NR = 1536, NC = 256;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cke_i = 1'b0, load_i = 1'b0, run_i = 1'b0, stop_i = 1'b0;
  logic [1:0] bank_i = '0;
  logic [10:0] row_i = '0;
  logic [7:0] col_i = '0;
  logic [1:0] bank_o;
  logic [10:0] row_o;
  logic [7:0] col_o;
  logic running_o, bank_sw_o, row_wrap_o;

  int checks = 0, errors = 0, cycles = 0;
  int m_bank = 0, m_row = 0, m_col = 0, m_run = 0, m_bsw = 0, m_rw = 0;

  always #4 clk_i = ~clk_i;

  bank_seq_addr_gen dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "bank", int'(bank_o), m_bank);
    chk(req, "row", int'(row_o), m_row);
    chk(req, "col", int'(col_o), m_col);
    chk(req, "running", int'(running_o), m_run);
    chk(req, "bank_sw", int'(bank_sw_o), m_bsw);
    chk(req, "row_wrap", int'(row_wrap_o), m_rw);
  endtask

  // one clock: drive, update model, advance, compare
  task automatic cyc(string req, bit ck, bit ld, bit rn, bit sp, int b, int r, int c);
    cke_i = ck; load_i = ld; run_i = rn; stop_i = sp;
    bank_i = 2'(b); row_i = 11'(r); col_i = 8'(c);
    m_bsw = 0; m_rw = 0;
    if (ck) begin
      if (sp) m_run = 0;
      else if (ld) begin
        m_bank = b; m_row = (r >= NR) ? 0 : r; m_col = c; m_run = 0;
      end else begin
        if (m_run != 0) begin
          if (m_col == NC - 1) begin
            m_col = 0; m_bsw = 1;
            if (m_bank == NB - 1) begin
              m_bank = 0;
              if (m_row == NR - 1) begin m_row = 0; m_rw = 1; end
              else m_row++;
            end else m_bank++;
          end else m_col++;
        end
        if (rn) m_run = 1;
      end
    end
    @(posedge clk_i); #2;
    cycles++;
    chk_all(req);
  endtask

  task automatic t_reset();
    chk_all("R1");
  endtask

  task automatic t_load();
    cyc("R2", 1, 1, 0, 0, 2, 100, 5);
    cyc("R2", 1, 0, 0, 0, 0, 0, 0);
    cyc("R2", 1, 1, 0, 0, 1, 2000, 77);
    cyc("R2", 1, 1, 1, 0, 3, 1535, 255);
  endtask

  task automatic t_run();
    cyc("R3", 1, 1, 0, 0, 0, 0, 250);
    cyc("R3", 1, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc("R3", 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_bank_order();
    cyc("R4", 1, 1, 0, 0, 0, 7, 254);
    cyc("R4", 1, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4 * NC + 4; i++) cyc("R4 R7", 1, 0, 0, 0, 0, 0, 0);
    chk("R5", "row after full pass", int'(row_o), 8);
  endtask

  task automatic t_row_step();
    cyc("R5", 1, 1, 0, 0, 3, 10, 254);
    cyc("R5", 1, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R5", 1, 0, 0, 0, 0, 0, 0);
    chk("R5", "row stepped", int'(row_o), 11);
  endtask

  task automatic t_row_wrap();
    cyc("R6", 1, 1, 0, 0, 3, 1535, 253);
    cyc("R6", 1, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc("R6", 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_cke();
    cyc("R8", 1, 1, 0, 0, 1, 20, 254);
    cyc("R8", 1, 0, 1, 0, 0, 0, 0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 1, 0, 0, 0, 0, 0, 0);
    cyc("R8", 1, 0, 0, 0, 0, 0, 0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_stop();
    cyc("R9", 1, 1, 0, 0, 2, 50, 10);
    cyc("R9", 1, 0, 1, 0, 0, 0, 0);
    cyc("R9", 1, 0, 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 1, 0, 0, 0);
    cyc("R10", 0, 1, 0, 0, 1, 1, 1);
    cyc("R10", 1, 0, 0, 0, 0, 0, 0);
    cyc("R9", 1, 1, 1, 1, 3, 3, 3);
    cyc("R9", 1, 0, 0, 0, 0, 0, 0);
    cyc("R9", 1, 0, 1, 0, 0, 0, 0);
    cyc("R10", 0, 0, 1, 0, 0, 0, 0);
    cyc("R9", 1, 0, 0, 1, 0, 0, 0);
    cyc("R9", 1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(posedge clk_i); #2;
    t_reset();
    t_load();
    t_run();
    t_bank_order();
    t_row_step();
    t_row_wrap();
    t_cke();
    t_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule